// File: doc/BRIEF.md
# Chained DMA Descriptor Walker

This block is the descriptor processor of an internal DMA engine. Software builds a list of four-word descriptors in memory, points the block at the first one and kicks it with a poll-demand write. The block reads each descriptor through a simple request/acknowledge memory port. A descriptor that software has handed over (ownership bit set) has its one or two buffers passed, one at a time, to an external data mover as address/length requests. Once those are done, the block writes the flags word back with ownership cleared and advances to the next descriptor.

The next descriptor is found in one of three ways: the pointer held in the descriptor (chained mode), the base address (end of ring), or the following 16-byte slot. The walk halts after a descriptor flagged last. It suspends on a descriptor that software still owns, and either halt is resumed by another poll demand. Each completed descriptor may set a transmit- or receive-complete status bit, unless the descriptor asks for its interrupt to be suppressed. An enabled summary bit drives the interrupt line.

Top module: `desc_walker`

## Requirements
- R1: After reset the base (index 0), mode (index 1), status (index 3) and current-pointer (index 5) registers read 0, and mem_req, xfer_req and irq are low.
- R2: A fetch reads the descriptor words at cur+0, cur+4, cur+8 and cur+12 in that order. If word 0 bit 31 (owned) is clear, only word 0 is read and the engine suspends with no transfer, no write-back and cur unchanged.
- R3: Buffer 1 is sent to the mover with address word 2 and length word 1 bits 12:0. When word 0 bit 4 (chained) is clear, buffer 2 follows with address word 3 and length word 1 bits 25:13. A zero length is skipped, and in chained mode buffer 2 is never sent.
- R4: After the buffers, word 0 is written back to cur with bit 31 cleared and all other bits unchanged.
- R5: The next pointer is the base register if word 0 bit 5 (end of ring) is set, otherwise word 3 if bit 4 is set, otherwise cur+16. The current pointer reads at register index 5.
- R6: After the write-back of a descriptor with word 0 bit 2 (last) set, the engine stops and makes no more memory requests until a poll demand.
- R7: On the write-back of a descriptor with word 0 bit 1 clear, status bit 1 (when dir_rx is 1) or bit 0 (when dir_rx is 0) is set. Status bit 8 is set as well when the enable bit at the same position (register index 4) is set. With word 0 bit 1 set, status is unchanged.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it. irq equals status bit 8 AND enable bit 8.
- R9: A write of any value to register index 2 starts a stopped or suspended engine at cur. The write is ignored while mode bit 7 (enable) is 0.
- R10: Writing mode with bit 0 set resets the engine at once: requests drop on the next cycle and cur becomes the base. Bit 0 reads back 0, while bits 7 and 1 (fixed burst) are stored.
- R11: A base write while mode bit 7 is 0 also loads cur. While bit 7 is 1, a base write leaves cur alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| dir_rx | input | 1 | Transfer direction, 1 = receive |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, read data valid with it |
| mem_rdata | input | 32 | Memory read data |
| xfer_req | output | 1 | Buffer transfer request, held until done |
| xfer_addr | output | AW | Buffer address |
| xfer_len | output | 13 | Buffer length in bytes |
| xfer_done | input | 1 | Data mover finished the buffer |
| irq | output | 1 | Interrupt line |

## Verification
The hardest states to reach from the ports are the suspend on an unowned descriptor and the software reset that lands in the middle of a transfer. The bench reaches the first by polling again at a ring slot whose flags word the engine has already written back. It counts the memory reads to show that exactly one happened, then sets ownership in memory and polls a third time to see the walk resume. For the second, the bench makes its data-mover model withhold completion, waits until the buffer request is up, then issues the reset and sees the request drop while the pointer returns to the base.

// File: rtl/dw_pkg.sv
package dw_pkg;
    localparam int WORD_W = 32;
    localparam int SZ_W   = 13;

    // descriptor word 0 flag positions
    localparam int F_OWN = 31;
    localparam int F_CES = 30;
    localparam int F_EOR = 5;
    localparam int F_CHN = 4;
    localparam int F_FST = 3;
    localparam int F_LST = 2;
    localparam int F_NOI = 1;

    // register word indexes
    localparam logic [2:0] RA_BASE = 3'd0;
    localparam logic [2:0] RA_MODE = 3'd1;
    localparam logic [2:0] RA_POLL = 3'd2;
    localparam logic [2:0] RA_STAT = 3'd3;
    localparam logic [2:0] RA_IEN  = 3'd4;
    localparam logic [2:0] RA_CUR  = 3'd5;

    // mode register bits
    localparam int M_RST = 0;
    localparam int M_FIX = 1;
    localparam int M_EN  = 7;

    // status / enable bits
    localparam int B_TX  = 0;
    localparam int B_RX  = 1;
    localparam int B_SUM = 8;

    typedef enum logic [2:0] {
        S_WAIT = 3'd0,
        S_RD   = 3'd1,
        S_XF1  = 3'd2,
        S_XF2  = 3'd3,
        S_WB   = 3'd4
    } wstate_e;
endpackage

// File: rtl/dw_regs.sv
module dw_regs
    import dw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [AW-1:0]     cur_ptr,
    input  logic              cmpl,
    input  logic              cmpl_rx,
    output logic [AW-1:0]     base,
    output logic              dma_en,
    output logic              sw_rst,
    output logic              poll,
    output logic              base_ld,
    output logic              irq
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic          fixb;
        logic          en;
        logic [2:0]    sts;   // {sum, rx, tx}
        logic [2:0]    ien;   // {sum, rx, tx}
    } regs_t;

    regs_t r_q, r_d;

    logic wr_mode, wr_stat, wr_ien, wr_base;
    logic [2:0] clr, set;

    always_comb begin
        wr_base = reg_we && (reg_addr == RA_BASE);
        wr_mode = reg_we && (reg_addr == RA_MODE);
        wr_stat = reg_we && (reg_addr == RA_STAT);
        wr_ien  = reg_we && (reg_addr == RA_IEN);
        sw_rst  = wr_mode && reg_wdata[M_RST];
        poll    = reg_we && (reg_addr == RA_POLL) && r_q.en;
        base_ld = wr_base && !r_q.en;

        clr = wr_stat ? {reg_wdata[B_SUM], reg_wdata[B_RX], reg_wdata[B_TX]} : 3'b000;
        set = 3'b000;
        if (cmpl) begin
            if (cmpl_rx) begin
                set[1] = 1'b1;
                set[2] = r_q.ien[1];
            end else begin
                set[0] = 1'b1;
                set[2] = r_q.ien[0];
            end
        end

        r_d = r_q;
        if (wr_base) r_d.base = reg_wdata[AW-1:0];
        if (wr_mode) begin
            r_d.fixb = reg_wdata[M_FIX];
            r_d.en   = reg_wdata[M_EN];
        end
        if (wr_ien) r_d.ien = {reg_wdata[B_SUM], reg_wdata[B_RX], reg_wdata[B_TX]};
        r_d.sts = (r_q.sts & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_BASE: reg_rdata = WORD_W'(r_q.base);
            RA_MODE: begin
                reg_rdata[M_EN]  = r_q.en;
                reg_rdata[M_FIX] = r_q.fixb;
            end
            RA_STAT: begin
                reg_rdata[B_SUM] = r_q.sts[2];
                reg_rdata[B_RX]  = r_q.sts[1];
                reg_rdata[B_TX]  = r_q.sts[0];
            end
            RA_IEN: begin
                reg_rdata[B_SUM] = r_q.ien[2];
                reg_rdata[B_RX]  = r_q.ien[1];
                reg_rdata[B_TX]  = r_q.ien[0];
            end
            RA_CUR:  reg_rdata = WORD_W'(cur_ptr);
            default: reg_rdata = '0;
        endcase
    end

    assign base   = r_q.base;
    assign dma_en = r_q.en;
    assign irq    = r_q.sts[2] && r_q.ien[2];
endmodule

// File: rtl/dw_engine.sv
module dw_engine
    import dw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     base,
    input  logic              sw_rst,
    input  logic              poll,
    input  logic              base_ld,
    input  logic [AW-1:0]     base_wval,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_req,
    output logic [AW-1:0]     xfer_addr,
    output logic [SZ_W-1:0]   xfer_len,
    input  logic              xfer_done,
    output logic              cmpl,
    output logic [AW-1:0]     cur_ptr
);
    localparam int NWORDS     = 4;
    localparam int DESC_BYTES = NWORDS * (WORD_W / 8);
    localparam int IDX_W      = $clog2(NWORDS);

    typedef struct packed {
        wstate_e                       st;
        logic [AW-1:0]                 cur;
        logic [IDX_W-1:0]              idx;
        logic [NWORDS-1:0][WORD_W-1:0] w;
    } eng_t;

    eng_t q, d;

    logic [SZ_W-1:0] sz1, sz2;
    logic            ring, has2;
    logic [AW-1:0]   nxt;

    always_comb begin
        sz1  = q.w[1][SZ_W-1:0];
        sz2  = q.w[1][2*SZ_W-1:SZ_W];
        ring = !q.w[0][F_CHN];
        has2 = ring && (sz2 != '0);
        if (q.w[0][F_EOR])      nxt = base;
        else if (!ring)         nxt = q.w[3][AW-1:0];
        else                    nxt = q.cur + AW'(DESC_BYTES);

        d    = q;
        cmpl = 1'b0;
        case (q.st)
            S_WAIT: begin
                if (poll) begin
                    d.st  = S_RD;
                    d.idx = '0;
                end
            end
            S_RD: begin
                if (mem_ack) begin
                    d.w[q.idx] = mem_rdata;
                    if (q.idx == '0 && !mem_rdata[F_OWN]) begin
                        d.st = S_WAIT;
                    end else if (q.idx == IDX_W'(NWORDS - 1)) begin
                        if (sz1 != '0)  d.st = S_XF1;
                        else if (has2)  d.st = S_XF2;
                        else            d.st = S_WB;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            S_XF1: begin
                if (xfer_done) d.st = has2 ? S_XF2 : S_WB;
            end
            S_XF2: begin
                if (xfer_done) d.st = S_WB;
            end
            S_WB: begin
                if (mem_ack) begin
                    cmpl  = !q.w[0][F_NOI];
                    d.cur = nxt;
                    d.idx = '0;
                    d.st  = q.w[0][F_LST] ? S_WAIT : S_RD;
                end
            end
            default: d.st = S_WAIT;
        endcase

        if (sw_rst) begin
            d.st  = S_WAIT;
            d.cur = base;
            d.idx = '0;
        end else if (base_ld) begin
            d.cur = base_wval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_WAIT;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_req   = (q.st == S_RD) || (q.st == S_WB);
        mem_we    = (q.st == S_WB);
        mem_addr  = (q.st == S_RD) ? q.cur + AW'({q.idx, 2'b00}) : q.cur;
        mem_wdata = q.w[0] & ~(WORD_W'(1) << F_OWN);
        xfer_req  = (q.st == S_XF1) || (q.st == S_XF2);
        xfer_addr = (q.st == S_XF2) ? q.w[3][AW-1:0] : q.w[2][AW-1:0];
        xfer_len  = (q.st == S_XF2) ? sz2 : sz1;
        cur_ptr   = q.cur;
    end
endmodule

// File: rtl/desc_walker.sv
module desc_walker
    import dw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dir_rx,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              xfer_req,
    output logic [AW-1:0]     xfer_addr,
    output logic [12:0]       xfer_len,
    input  logic              xfer_done,
    output logic              irq
);
    logic [AW-1:0] base, cur_ptr;
    logic          dma_en, sw_rst, poll, base_ld, cmpl;

    dw_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cur_ptr   (cur_ptr),
        .cmpl      (cmpl),
        .cmpl_rx   (dir_rx),
        .base      (base),
        .dma_en    (dma_en),
        .sw_rst    (sw_rst),
        .poll      (poll),
        .base_ld   (base_ld),
        .irq       (irq)
    );

    dw_engine #(.AW(AW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .base      (base),
        .sw_rst    (sw_rst),
        .poll      (poll),
        .base_ld   (base_ld),
        .base_wval (reg_wdata[AW-1:0]),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .xfer_req  (xfer_req),
        .xfer_addr (xfer_addr),
        .xfer_len  (xfer_len),
        .xfer_done (xfer_done),
        .cmpl      (cmpl),
        .cur_ptr   (cur_ptr)
    );

    logic unused_en;
    assign unused_en = dma_en;
endmodule

// File: rtl/dw_chk.sv
module dw_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          xfer_req,
    input logic [AW-1:0] xfer_addr,
    input logic [12:0]   xfer_len,
    input logic          xfer_done,
    input logic          irq
);
    logic rst_wr, ien_wr;
    assign rst_wr = reg_we && (reg_addr == 3'd1) && reg_wdata[0];
    assign ien_wr = reg_we && (reg_addr == 3'd4);

    // R2: a memory request stays up with a stable address until acknowledged
    a_r2_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !rst_wr |=> mem_req && $stable(mem_addr));

    // R3: a buffer request stays up with a stable address until done, never empty
    a_r3_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_done && !rst_wr |=> xfer_req && $stable(xfer_addr));
    a_r3_xfer_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> xfer_len != 13'd0);

    // R3: memory and mover are never requested together
    a_r3_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && xfer_req));

    // R4: written-back flags never carry ownership
    a_r4_wb_own: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]);

    // R7: interrupt rises only after a write-back or an enable write
    a_r7_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_req && mem_we && mem_ack) || $past(ien_wr));

    // R10: software reset drops every request on the next cycle
    a_r10_rst_abort: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> !mem_req && !xfer_req);
endmodule

bind desc_walker dw_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .xfer_req  (xfer_req),
    .xfer_addr (xfer_addr),
    .xfer_len  (xfer_len),
    .xfer_done (xfer_done),
    .irq       (irq)
);

// File: tb/tb_desc_walker.sv
`timescale 1ns/1ps
module tb_desc_walker;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          dir_rx = 1'b0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          xfer_req;
    logic [AW-1:0] xfer_addr;
    logic [12:0]   xfer_len;
    logic          xfer_done = 1'b0;
    logic          irq;

    desc_walker #(.AW(AW)) dut (.*);

    always #2.5 clk = ~clk;

    logic [31:0] mem [0:511];
    logic [31:0] rd_log [0:63];
    logic [31:0] xa_log [0:15];
    logic [12:0] xl_log [0:15];
    int rd_cnt = 0, wb_cnt = 0, xn = 0;
    int n_chk = 0, n_bad = 0;
    bit hold_mover = 1'b0;
    bit done_flag = 1'b0;

    // memory model
    initial forever begin
        @(posedge clk); #1;
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                mem[mem_addr[10:2]] = mem_wdata;
                wb_cnt++;
            end else begin
                mem_rdata = mem[mem_addr[10:2]];
                if (rd_cnt < 64) rd_log[rd_cnt] = mem_addr;
                rd_cnt++;
            end
        end
    end

    // data mover model
    initial forever begin
        @(posedge clk); #1;
        if (xfer_done) xfer_done = 1'b0;
        else if (xfer_req && !hold_mover) begin
            xfer_done = 1'b1;
            if (xn < 16) begin
                xa_log[xn] = xfer_addr;
                xl_log[xn] = xfer_len;
            end
            xn++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_wb(input int n);
        for (int i = 0; i < 3000 && wb_cnt < n; i++) @(posedge clk);
        repeat (8) @(posedge clk);
    endtask

    task automatic put_desc(input int a, input logic [31:0] w0, w1, w2, w3);
        mem[a>>2] = w0; mem[(a>>2)+1] = w1; mem[(a>>2)+2] = w2; mem[(a>>2)+3] = w3;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd_reg(3'd3, v); chk("R1 status", v, 32'h0);
        rd_reg(3'd1, v); chk("R1 mode", v, 32'h0);
        rd_reg(3'd5, v); chk("R1 cur", v, 32'h0);
        rd_reg(3'd0, v); chk("R1 base", v, 32'h0);
        chk("R1 outputs", {29'b0, irq, mem_req, xfer_req}, 32'h0);
    endtask

    task automatic t_chain;
        logic [31:0] v;
        put_desc(32'h100, 32'h8000001A, 32'd64 | (32'd100 << 13), 32'h1000, 32'h200);
        put_desc(32'h200, 32'h80000014, 32'd32, 32'h2000, 32'h300);
        wr_reg(3'd0, 32'h100);
        rd_reg(3'd5, v); chk("R11 cur loads while disabled", v, 32'h100);
        wr_reg(3'd4, 32'h103);
        wr_reg(3'd1, 32'h80);
        wr_reg(3'd2, 32'h0);
        wait_wb(2);
        chk("R2 read order w0", rd_log[0], 32'h100);
        chk("R2 read order w1", rd_log[1], 32'h104);
        chk("R2 read order w2", rd_log[2], 32'h108);
        chk("R2 read order w3", rd_log[3], 32'h10C);
        chk("R3 chained count", xn, 2);
        chk("R3 buf addr 0", xa_log[0], 32'h1000);
        chk("R3 buf len 0", 32'(xl_log[0]), 64);
        chk("R3 buf addr 1", xa_log[1], 32'h2000);
        chk("R3 buf len 1", 32'(xl_log[1]), 32);
        chk("R4 writeback d0", mem[32'h100>>2], 32'h0000001A);
        chk("R4 writeback d1", mem[32'h200>>2], 32'h00000014);
        rd_reg(3'd3, v); chk("R7 status tx+sum", v, 32'h101);
        chk("R8 irq high", 32'(irq), 1);
        rd_reg(3'd5, v); chk("R5 chained next", v, 32'h300);
        repeat (30) @(posedge clk);
        chk("R6 stopped after last", rd_cnt, 8);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr_reg(3'd3, 32'h001);
        rd_reg(3'd3, v); chk("R8 clear tx only", v, 32'h100);
        chk("R8 irq kept", 32'(irq), 1);
        wr_reg(3'd3, 32'h100);
        rd_reg(3'd3, v); chk("R8 clear sum", v, 32'h0);
        chk("R8 irq low", 32'(irq), 0);
    endtask

    task automatic t_noint;
        logic [31:0] v;
        put_desc(32'h300, 32'h80000016, 32'd16, 32'h2800, 32'h400);
        wr_reg(3'd2, 32'h5A);
        wait_wb(3);
        chk("R9 poll restarts", xn, 3);
        chk("R3 buf addr 2", xa_log[2], 32'h2800);
        rd_reg(3'd3, v); chk("R7 suppressed status", v, 32'h0);
        chk("R7 suppressed irq", 32'(irq), 0);
        rd_reg(3'd5, v); chk("R5 next 400", v, 32'h400);
    endtask

    task automatic t_ring;
        logic [31:0] v;
        wr_reg(3'd0, 32'h500);
        rd_reg(3'd5, v); chk("R11 cur kept while enabled", v, 32'h400);
        wr_reg(3'd1, 32'h83);
        rd_reg(3'd1, v); chk("R10 mode readback", v, 32'h82);
        rd_reg(3'd5, v); chk("R10 cur to base", v, 32'h500);
        put_desc(32'h500, 32'h80000000, 32'd8 | (32'd12 << 13), 32'h3000, 32'h3100);
        put_desc(32'h510, 32'h80000024, (32'd20 << 13), 32'h3180, 32'h3200);
        dir_rx = 1'b1;
        wr_reg(3'd2, 32'h0);
        wait_wb(5);
        chk("R3 ring count", xn, 6);
        chk("R3 ring buf1", xa_log[3], 32'h3000);
        chk("R3 ring len1", 32'(xl_log[3]), 8);
        chk("R3 ring buf2", xa_log[4], 32'h3100);
        chk("R3 ring len2", 32'(xl_log[4]), 12);
        chk("R3 zero skipped", xa_log[5], 32'h3200);
        chk("R3 zero skipped len", 32'(xl_log[5]), 20);
        chk("R4 ring wb0", mem[32'h500>>2], 32'h0);
        chk("R4 ring wb1", mem[32'h510>>2], 32'h24);
        rd_reg(3'd5, v); chk("R5 end of ring wrap", v, 32'h500);
        rd_reg(3'd3, v); chk("R7 status rx+sum", v, 32'h102);
    endtask

    task automatic t_suspend;
        logic [31:0] v;
        int r0;
        wr_reg(3'd3, 32'h103);
        r0 = rd_cnt;
        wr_reg(3'd2, 32'h0);
        repeat (20) @(posedge clk);
        chk("R2 unowned single read", rd_cnt, r0 + 1);
        chk("R2 unowned no transfer", xn, 6);
        chk("R2 unowned no writeback", wb_cnt, 5);
        rd_reg(3'd5, v); chk("R2 unowned cur kept", v, 32'h500);
        put_desc(32'h500, 32'h80000004, 32'd4, 32'h3300, 32'h0);
        wr_reg(3'd2, 32'h0);
        wait_wb(6);
        chk("R9 resume transfer", xa_log[6], 32'h3300);
        rd_reg(3'd5, v); chk("R9 resume next", v, 32'h510);
    endtask

    task automatic t_disabled;
        int r0;
        wr_reg(3'd1, 32'h0);
        put_desc(32'h510, 32'h80000004, 32'd4, 32'h3400, 32'h0);
        r0 = rd_cnt;
        wr_reg(3'd2, 32'h0);
        repeat (20) @(posedge clk);
        chk("R9 poll ignored when disabled", rd_cnt, r0);
    endtask

    task automatic t_abort;
        logic [31:0] v;
        wr_reg(3'd1, 32'h80);
        hold_mover = 1'b1;
        wr_reg(3'd2, 32'h0);
        for (int i = 0; i < 200 && !xfer_req; i++) @(posedge clk);
        chk("R10 transfer pending", 32'(xfer_req), 1);
        wr_reg(3'd1, 32'h81);
        #1 chk("R10 transfer dropped", 32'(xfer_req), 0);
        rd_reg(3'd5, v); chk("R10 abort cur to base", v, 32'h500);
        hold_mover = 1'b0;
        repeat (10) @(posedge clk);
        chk("R10 no later transfer", xn, 7);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_chain();
        t_w1c();
        t_noint();
        t_ring();
        t_suspend();
        t_disabled();
        t_abort();
        done_flag = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000 && !done_flag; i++) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule